// File: doc/BRIEF.md
# Segment:Offset Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit byte address for a 16-bit processor core. It keeps four segment registers: code, data, stack and extra. It also keeps the instruction pointer. Each cycle the core states what kind of memory access it wants and supplies the offset from the matching pointer or index register. The block then picks the segment register for that access and forms the address. The address is the segment shifted left by four bit positions plus the offset.

An optional override lets a stack-kind or data-kind access use any of the four segment registers in place of its default. Instruction fetches and string-destination accesses always use their fixed segment.

Segment registers are written through a load port. The instruction pointer has no general write path. It either steps forward by the length of the instruction just taken, or is reloaded by a dedicated control-transfer input.

Top module: `seg_addr_gen`

## Requirements
- R1: The address `phys_addr` equals (selected segment × 16) + offset, reduced modulo 2^20. Any carry out of bit 19 is dropped, so FFFF:FFFF gives 0FFEFh and A4FB:4827 gives A97D7h.
- R2: When `acc_kind` is 0 (fetch), the code segment is used and the offset is the instruction pointer. `acc_off` has no effect on the address.
- R3: When `acc_kind` is 1 (stack) and there is no override, the stack segment is used with `acc_off` as the offset.
- R4: When `acc_kind` is 2 (data) and there is no override, the data segment is used with `acc_off` as the offset.
- R5: When `acc_kind` is 3 (string destination), the extra segment is used with `acc_off`, whatever the override inputs hold.
- R6: When `ovr_valid` is high and `acc_kind` is 1 or 2, the segment named by `ovr_seg` is used in place of the default.
- R7: A fetch ignores `ovr_valid` and `ovr_seg`.
- R8: A write through `seg_we`/`seg_sel`/`seg_wdata` changes the address only from the clock edge after the write. In the write cycle itself the old value is still used.
- R9: When `ip_adv` is high and `ip_jmp` is low, the instruction pointer grows by `ip_inc` at the clock edge, modulo 2^16. With neither input high, it holds its value.
- R10: When `ip_jmp` is high, the instruction pointer loads `jmp_off` at the clock edge. This takes priority over `ip_adv`.
- R11: A synchronous reset sets the code segment to FFFFh, sets the data, stack and extra segments to 0000h, and sets the instruction pointer to 0000h, so the first fetch address is FFFF0h. Reset takes priority over every load.
- R12: `seg_used` reports the segment register behind the current address, using the codes 0 = code, 1 = data, 2 = stack, 3 = extra. `seg_sel` and `ovr_seg` use the same codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seg_we | input | 1 | Segment register write enable |
| seg_sel | input | 2 | Segment register to write (code 0..3) |
| seg_wdata | input | 16 | Value to write into the segment register |
| ip_adv | input | 1 | Advance the instruction pointer |
| ip_inc | input | 3 | Length of the instruction just taken, in bytes |
| ip_jmp | input | 1 | Reload the instruction pointer (control transfer) |
| jmp_off | input | 16 | New instruction pointer value |
| acc_kind | input | 2 | Access kind: 0 fetch, 1 stack, 2 data, 3 string destination |
| acc_off | input | 16 | Offset for access kinds other than fetch |
| ovr_valid | input | 1 | Segment override request |
| ovr_seg | input | 2 | Segment to use when the override applies |
| phys_addr | output | 20 | Physical byte address |
| seg_used | output | 2 | Segment register that formed `phys_addr` |
| ip_out | output | 16 | Current instruction pointer |

## Verification
The assertions assume that the reset input is a clean level sampled on the clock. They also assume that the override inputs have meaning only when `ovr_valid` is high. Both assumptions hold for any value on the other inputs, so the stimulus drives every input freely: fully random values, including simultaneous jump and advance, and writes to the segment register that the current access is reading. Directed cycles cover the reset address, the worked example, and the wrap past 2^20. They also cover the same-cycle write ordering and the override reaching into a string destination or a fetch.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W   = 16,
  parameter int OFF_W   = 16,
  parameter int SHIFT   = 4,
  parameter int INC_W   = 3,
  parameter logic [SEG_W-1:0] CODE_RST = '1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    seg_we,
  input  logic [1:0]              seg_sel,
  input  logic [SEG_W-1:0]        seg_wdata,
  input  logic                    ip_adv,
  input  logic [INC_W-1:0]        ip_inc,
  input  logic                    ip_jmp,
  input  logic [OFF_W-1:0]        jmp_off,
  input  logic [1:0]              acc_kind,
  input  logic [OFF_W-1:0]        acc_off,
  input  logic                    ovr_valid,
  input  logic [1:0]              ovr_seg,
  output logic [SEG_W+SHIFT-1:0]  phys_addr,
  output logic [1:0]              seg_used,
  output logic [OFF_W-1:0]        ip_out
);
  localparam int ADDR_W = SEG_W + SHIFT;
  localparam logic [1:0] S_CODE = 2'd0, S_DATA = 2'd1, S_STACK = 2'd2, S_EXTRA = 2'd3;
  localparam logic [1:0] K_FETCH = 2'd0, K_STACK = 2'd1, K_DATA = 2'd2, K_STR = 2'd3;

  logic [SEG_W-1:0] seg_q [4];
  logic [OFF_W-1:0] ip_q;
  logic [1:0]       sel;
  logic [OFF_W-1:0] off;

  for (genvar g = 0; g < 4; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst)
        seg_q[g] <= (g == S_CODE) ? CODE_RST : '0;
      else if (seg_we && seg_sel == g[1:0])
        seg_q[g] <= seg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         ip_q <= '0;
    else if (ip_jmp) ip_q <= jmp_off;
    else if (ip_adv) ip_q <= ip_q + OFF_W'(ip_inc);
  end

  always_comb begin
    unique case (acc_kind)
      K_FETCH: sel = S_CODE;
      K_STACK: sel = ovr_valid ? ovr_seg : S_STACK;
      K_DATA:  sel = ovr_valid ? ovr_seg : S_DATA;
      default: sel = S_EXTRA;
    endcase
  end

  assign off       = (acc_kind == K_FETCH) ? ip_q : acc_off;
  assign phys_addr = {seg_q[sel], {SHIFT{1'b0}}} + ADDR_W'(off);
  assign seg_used  = sel;
  assign ip_out    = ip_q;

  assert_reset_fetch_R11: assert property (@(posedge clk)
    rst |=> (ip_out == '0 && (acc_kind != K_FETCH || phys_addr == {CODE_RST, {SHIFT{1'b0}}})));

  assert_ip_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!ip_jmp && !ip_adv) |=> $stable(ip_out));

  assert_ip_step_R9: assert property (@(posedge clk) disable iff (rst)
    (ip_adv && !ip_jmp) |=> ip_out == $past(ip_out) + OFF_W'($past(ip_inc)));

  assert_jump_wins_R10: assert property (@(posedge clk) disable iff (rst)
    ip_jmp |=> ip_out == $past(jmp_off));

  assert_code_load_visible_R8: assert property (@(posedge clk) disable iff (rst)
    (seg_we && seg_sel == S_CODE) |=>
      (acc_kind != K_FETCH || phys_addr == {$past(seg_wdata), {SHIFT{1'b0}}} + ADDR_W'(ip_out)));

  assert_str_dest_extra_R5: assert property (@(posedge clk) disable iff (rst)
    acc_kind == K_STR |-> seg_used == S_EXTRA);

  assert_fetch_no_override_R7: assert property (@(posedge clk) disable iff (rst)
    acc_kind == K_FETCH |-> seg_used == S_CODE);

  assert_override_taken_R6: assert property (@(posedge clk) disable iff (rst)
    (ovr_valid && (acc_kind == K_STACK || acc_kind == K_DATA)) |-> seg_used == ovr_seg);
endmodule

// File: tb/seg_addr_gen_tb_top.sv
`timescale 1ns/1ps
module seg_addr_gen_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        seg_we = 0;
  logic [1:0]  seg_sel = 0;
  logic [15:0] seg_wdata = 0;
  logic        ip_adv = 0;
  logic [2:0]  ip_inc = 0;
  logic        ip_jmp = 0;
  logic [15:0] jmp_off = 0;
  logic [1:0]  acc_kind = 0;
  logic [15:0] acc_off = 0;
  logic        ovr_valid = 0;
  logic [1:0]  ovr_seg = 0;
  logic [19:0] phys_addr;
  logic [1:0]  seg_used;
  logic [15:0] ip_out;

  int checks = 0, fails = 0;
  int m_seg [4];
  int m_ip;
  bit done = 0;

  always #4 clk = ~clk;

  seg_addr_gen dut_i (
    .clk(clk), .rst(rst), .seg_we(seg_we), .seg_sel(seg_sel), .seg_wdata(seg_wdata),
    .ip_adv(ip_adv), .ip_inc(ip_inc), .ip_jmp(ip_jmp), .jmp_off(jmp_off),
    .acc_kind(acc_kind), .acc_off(acc_off), .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
    .phys_addr(phys_addr), .seg_used(seg_used), .ip_out(ip_out));

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string kind_tag(int k, bit ov);
    if (k == 0) return "R2";
    if (k == 3) return "R5";
    if (ov) return "R6";
    return (k == 1) ? "R3" : "R4";
  endfunction

  // drive at negedge, compare before the posedge, then advance the model
  task automatic step(string tag);
    int sel, off, exp_addr;
    string t;
    #2;
    case (acc_kind)
      0: sel = 0;
      1: sel = ovr_valid ? int'(ovr_seg) : 2;
      2: sel = ovr_valid ? int'(ovr_seg) : 1;
      default: sel = 3;
    endcase
    off = (acc_kind == 0) ? m_ip : int'(acc_off);
    exp_addr = (m_seg[sel] * 16 + off) % (1 << 20);
    t = (tag == "") ? kind_tag(acc_kind, ovr_valid) : tag;
    check(t, "phys_addr", int'(phys_addr), exp_addr);
    check("R12", "seg_used", int'(seg_used), sel);
    check((tag == "R11") ? "R11" : (ip_jmp ? "R10" : "R9"), "ip_out", int'(ip_out), m_ip);
    @(posedge clk);
    if (rst) begin
      m_seg[0] = 16'hFFFF; m_seg[1] = 0; m_seg[2] = 0; m_seg[3] = 0; m_ip = 0;
    end else begin
      if (seg_we) m_seg[seg_sel] = int'(seg_wdata);
      if (ip_jmp) m_ip = int'(jmp_off);
      else if (ip_adv) m_ip = (m_ip + int'(ip_inc)) % 65536;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    seg_we = 0; ip_adv = 0; ip_jmp = 0; ovr_valid = 0;
  endtask

  initial begin
    m_seg[0] = 0; m_seg[1] = 0; m_seg[2] = 0; m_seg[3] = 0; m_ip = 0;
    // model state is unknown before the first edge: take the reset edge unchecked
    @(posedge clk);
    m_seg[0] = 16'hFFFF; m_ip = 0;
    @(negedge clk);
    rst = 0;
    acc_kind = 0; acc_off = 16'h1234;
    step("R11");
    // R8: load DS while reading it: old value this cycle, new one after
    seg_we = 1; seg_sel = 1; seg_wdata = 16'hA4FB; acc_kind = 2; acc_off = 16'h4827;
    step("R8");
    idle();
    step("R1");
    check("R1", "worked example", int'(phys_addr), 'hA97D7);
    // R1 wrap
    seg_we = 1; seg_sel = 3; seg_wdata = 16'hFFFF; step("R1");
    idle(); acc_kind = 3; acc_off = 16'hFFFF; step("R1");
    check("R1", "wrap", int'(phys_addr), 'h0FFEF);
    // R5/R7 override ignored
    ovr_valid = 1; ovr_seg = 1; acc_kind = 3; step("R5");
    acc_kind = 0; ovr_seg = 2; step("R7");
    // R6 override on stack kind
    acc_kind = 1; ovr_seg = 3; step("R6");
    // R10 jump beats advance; R9 wrap
    idle(); ip_jmp = 1; ip_adv = 1; ip_inc = 3; jmp_off = 16'hFFFE; step("R10");
    idle(); ip_adv = 1; ip_inc = 5; step("R9");
    idle(); step("R9");
    check("R9", "ip wrap", int'(ip_out), 3);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      rst       = ($urandom_range(0, 199) == 0);
      seg_we    = ($urandom_range(0, 3) == 0);
      seg_sel   = 2'($urandom);
      seg_wdata = 16'($urandom);
      ip_adv    = $urandom_range(0, 1) == 1;
      ip_inc    = 3'($urandom);
      ip_jmp    = ($urandom_range(0, 7) == 0);
      jmp_off   = 16'($urandom);
      acc_kind  = 2'($urandom);
      acc_off   = 16'($urandom);
      ovr_valid = $urandom_range(0, 1) == 1;
      ovr_seg   = 2'($urandom);
      step(rst ? "R11" : "");
    end
    rst = 0; idle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule